// File: doc/BRIEF.md
# Rotating-Parity Stripe Write Engine

This block sits between a single-block front end and five independent block stores that together form a parity-protected disk array. Every logical block number is split into a stripe number and a position inside the stripe. Each stripe keeps four data blocks and one parity block, and the disk that holds the parity moves from stripe to stripe. This spreads parity traffic over all five stores, so small writes to different stripes can land on disjoint disks.

A write to one block is done as an incremental update. The engine reads the old data and the old parity, forms the new parity as the XOR of old parity, old data and new data, and writes both blocks back. A read fetches one block from the disk that holds it. Only one front-end operation is in flight at a time. The back end gives each disk its own request/response channel, and each command goes to the stripe number as the on-disk block address.

Top module: `parity_stripe_engine`

## Requirements
- R1: The stripe number is the logical block number divided by 4 (`req_lba[LBA_W-1:2]`). The parity disk of stripe s is 4 − (s mod 5), so stripes 0,1,2,3,4 put parity on disks 4,3,2,1,0 and stripe 5 uses disk 4 again.
- R2: The in-stripe index is `req_lba[1:0]`. Data blocks take the four non-parity disks in increasing disk order: the data disk is the index, plus 1 when the index is greater than or equal to the parity disk number.
- R3: A single-block write makes exactly two reads (data disk, parity disk) and exactly two writes (the same two disks), and touches no other disk.
- R4: No write command is issued to any disk until both read responses of the same operation have arrived.
- R5: The parity written equals old parity XOR old data XOR new data, so the XOR of all five blocks of every stripe stays zero.
- R6: A disk command is held, with address, direction and data stable, until the disk accepts it (valid and ready high together). Its address is the stripe number.
- R7: `req_ready` is high only when the engine is idle. After reset it is high, with `rsp_done` low and no disk command pending. `rsp_done` is a one-cycle pulse that fires once the last response of the operation has been received.
- R8: A read issues one read to the data disk and no writes. It returns that block on `rsp_rdata` while `rsp_done` is high.
- R9: A write finishes correctly whether the two write acknowledgements arrive in the same cycle or in either order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Front-end operation request |
| req_ready | output | 1 | Engine idle and able to accept a request |
| req_write | input | 1 | 1 = single-block write, 0 = read |
| req_lba | input | LBA_W | Logical block number |
| req_wdata | input | DATA_W | New block data for a write |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_done on reads |
| dsk_req_valid | output | 5 | Per-disk command valid |
| dsk_req_ready | input | 5 | Per-disk command accept |
| dsk_req_write | output | 5 | Per-disk command direction, 1 = write |
| dsk_req_addr | output | 5 x (LBA_W-2) | Per-disk block address (stripe number) |
| dsk_req_wdata | output | 5 x DATA_W | Per-disk write data |
| dsk_rsp_valid | input | 5 | Per-disk response (read data or write acknowledge) |
| dsk_rsp_rdata | input | 5 x DATA_W | Per-disk read data |

## Verification
The two read responses, and later the two write acknowledgements, of a small write can reach the engine in the same cycle, from two separate disk channels. The bench creates this with a lockstep mode, in which every disk accepts at once and answers after a fixed single cycle. It also runs a random mode with random accept and response delays, which spreads the same events over arbitrary orders. In both modes the bench judges the result from the disk image it keeps: each stripe must XOR to zero, the data block and the parity block must sit at the rotated locations, and no write may be issued before both reads have returned.

// File: rtl/pse_pkg.sv
package pse_pkg;

    localparam int NDISK       = 5;
    localparam int DATA_PER_ST = 4;

    typedef logic [2:0] disk_idx_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD,
        ST_WR
    } eng_state_t;

    typedef enum logic [1:0] {
        SL_IDLE,
        SL_REQ,
        SL_WAIT,
        SL_FIN
    } slot_state_t;

    function automatic disk_idx_t parity_disk(input logic [31:0] stripe);
        return disk_idx_t'((NDISK - 1) - int'(stripe % NDISK));
    endfunction

    function automatic disk_idx_t data_disk(input logic [1:0] idx, input disk_idx_t pd);
        disk_idx_t base;
        base = disk_idx_t'(idx);
        return (base >= pd) ? base + 3'd1 : base;
    endfunction

endpackage

// File: rtl/stripe_mapper.sv
module stripe_mapper
    import pse_pkg::*;
#(
    parameter int LBA_W = 16,
    localparam int SA_W = LBA_W - 2
) (
    input  logic [LBA_W-1:0] lba,
    output logic [SA_W-1:0]  stripe,
    output disk_idx_t        par_disk,
    output disk_idx_t        dat_disk
);
    always_comb begin
        stripe   = lba[LBA_W-1:2];
        par_disk = parity_disk(32'(lba[LBA_W-1:2]));
        dat_disk = data_disk(lba[1:0], par_disk);
    end

    always_comb begin
        AST_DATA_NOT_PARITY: assert (dat_disk != par_disk); // R2
    end
endmodule

// File: rtl/disk_slot.sv
module disk_slot
    import pse_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AW     = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              start_write,
    input  logic [AW-1:0]     start_addr,
    input  logic [DATA_W-1:0] start_wdata,
    output logic              complete,
    output logic [DATA_W-1:0] rdata,
    output logic              d_req_valid,
    input  logic              d_req_ready,
    output logic              d_req_write,
    output logic [AW-1:0]     d_req_addr,
    output logic [DATA_W-1:0] d_req_wdata,
    input  logic              d_rsp_valid,
    input  logic [DATA_W-1:0] d_rsp_rdata
);
    slot_state_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= SL_IDLE;
            d_req_write <= 1'b0;
            d_req_addr  <= '0;
            d_req_wdata <= '0;
            rdata       <= '0;
        end else begin
            unique case (st)
                SL_IDLE, SL_FIN: if (start) begin
                    st          <= SL_REQ;
                    d_req_write <= start_write;
                    d_req_addr  <= start_addr;
                    d_req_wdata <= start_wdata;
                end
                SL_REQ:  if (d_req_ready) st <= SL_WAIT;
                SL_WAIT: if (d_rsp_valid) begin
                    st    <= SL_FIN;
                    rdata <= d_rsp_rdata;
                end
                default: st <= SL_IDLE;
            endcase
        end
    end

    assign d_req_valid = (st == SL_REQ);
    assign complete    = (st == SL_FIN);

    AST_CMD_HELD: assert property (@(posedge clk) disable iff (rst)
        d_req_valid && !d_req_ready |=> d_req_valid && $stable(d_req_addr)
        && $stable(d_req_write) && $stable(d_req_wdata)); // R6
    AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        start |-> !(st == SL_REQ || st == SL_WAIT)); // R4
endmodule

// File: rtl/parity_stripe_engine.sv
module parity_stripe_engine
    import pse_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LBA_W  = 16,
    localparam int SA_W  = LBA_W - 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic                         req_write,
    input  logic [LBA_W-1:0]             req_lba,
    input  logic [DATA_W-1:0]            req_wdata,
    output logic                         rsp_done,
    output logic [DATA_W-1:0]            rsp_rdata,
    output logic [NDISK-1:0]             dsk_req_valid,
    input  logic [NDISK-1:0]             dsk_req_ready,
    output logic [NDISK-1:0]             dsk_req_write,
    output logic [NDISK-1:0][SA_W-1:0]   dsk_req_addr,
    output logic [NDISK-1:0][DATA_W-1:0] dsk_req_wdata,
    input  logic [NDISK-1:0]             dsk_rsp_valid,
    input  logic [NDISK-1:0][DATA_W-1:0] dsk_rsp_rdata
);
    eng_state_t        st;
    logic [SA_W-1:0]   map_stripe, stripe_q;
    disk_idx_t         map_pd, map_dd, pd_q, dd_q;
    logic              is_wr_q;
    logic [DATA_W-1:0] wdata_q, new_par;
    logic [NDISK-1:0]  slot_cmpl, slot_start;
    logic [DATA_W-1:0] slot_rdata [NDISK];
    logic              accept, rd_ok, wr_ok;

    stripe_mapper #(.LBA_W(LBA_W)) i_map (
        .lba(req_lba), .stripe(map_stripe), .par_disk(map_pd), .dat_disk(map_dd)
    );

    assign req_ready = (st == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign rd_ok     = slot_cmpl[dd_q] && (!is_wr_q || slot_cmpl[pd_q]);
    assign wr_ok     = slot_cmpl[dd_q] && slot_cmpl[pd_q];
    assign new_par   = slot_rdata[pd_q] ^ slot_rdata[dd_q] ^ wdata_q;

    for (genvar i = 0; i < NDISK; i++) begin : g_slot
        assign slot_start[i] =
            (accept && (3'(i) == map_dd || (req_write && 3'(i) == map_pd))) ||
            (st == ST_RD && is_wr_q && rd_ok && (3'(i) == dd_q || 3'(i) == pd_q));

        disk_slot #(.DATA_W(DATA_W), .AW(SA_W)) i_slot (
            .clk(clk), .rst(rst),
            .start(slot_start[i]),
            .start_write(st == ST_RD),
            .start_addr((st == ST_IDLE) ? map_stripe : stripe_q),
            .start_wdata((3'(i) == pd_q) ? new_par : wdata_q),
            .complete(slot_cmpl[i]),
            .rdata(slot_rdata[i]),
            .d_req_valid(dsk_req_valid[i]),
            .d_req_ready(dsk_req_ready[i]),
            .d_req_write(dsk_req_write[i]),
            .d_req_addr(dsk_req_addr[i]),
            .d_req_wdata(dsk_req_wdata[i]),
            .d_rsp_valid(dsk_rsp_valid[i]),
            .d_rsp_rdata(dsk_rsp_rdata[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            stripe_q  <= '0;
            pd_q      <= '0;
            dd_q      <= '0;
            is_wr_q   <= 1'b0;
            wdata_q   <= '0;
            rsp_done  <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_done <= 1'b0;
            unique case (st)
                ST_IDLE: if (accept) begin
                    st       <= ST_RD;
                    stripe_q <= map_stripe;
                    pd_q     <= map_pd;
                    dd_q     <= map_dd;
                    is_wr_q  <= req_write;
                    wdata_q  <= req_wdata;
                end
                ST_RD: if (rd_ok) begin
                    if (is_wr_q) begin
                        st <= ST_WR;
                    end else begin
                        st        <= ST_IDLE;
                        rsp_done  <= 1'b1;
                        rsp_rdata <= slot_rdata[dd_q];
                    end
                end
                ST_WR: if (wr_ok) begin
                    st       <= ST_IDLE;
                    rsp_done <= 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    AST_WRITE_AFTER_READS: assert property (@(posedge clk) disable iff (rst)
        |(dsk_req_valid & dsk_req_write) |-> st == ST_WR); // R4
    AST_TWO_DISKS_MAX: assert property (@(posedge clk) disable iff (rst)
        $countones(dsk_req_valid) <= 2); // R3
    AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        st != ST_IDLE && !is_wr_q |-> !(|(dsk_req_valid & dsk_req_write))); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done); // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> req_ready); // R7
endmodule

// File: tb/test_parity_stripe_engine.sv
module test_parity_stripe_engine;
    localparam int CLK_PERIOD = 10;
    localparam int DW   = 32;
    localparam int LW   = 16;
    localparam int AW   = LW - 2;
    localparam int ND   = 5;
    localparam int NSTR = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [LW-1:0] req_lba = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_done;
    logic [DW-1:0] rsp_rdata;
    logic [ND-1:0] dsk_req_valid, dsk_req_write;
    logic [ND-1:0] dsk_req_ready = '0;
    logic [ND-1:0] dsk_rsp_valid = '0;
    logic [ND-1:0][AW-1:0] dsk_req_addr;
    logic [ND-1:0][DW-1:0] dsk_req_wdata;
    logic [ND-1:0][DW-1:0] dsk_rsp_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    parity_stripe_engine #(.DATA_W(DW), .LBA_W(LW)) i_parity_stripe_engine (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_lba(req_lba), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .dsk_req_valid(dsk_req_valid), .dsk_req_ready(dsk_req_ready),
        .dsk_req_write(dsk_req_write), .dsk_req_addr(dsk_req_addr),
        .dsk_req_wdata(dsk_req_wdata), .dsk_rsp_valid(dsk_rsp_valid),
        .dsk_rsp_rdata(dsk_rsp_rdata)
    );

    // disk image and reference
    logic [DW-1:0] dmem [ND][NSTR];
    logic [DW-1:0] ref_blk [4*NSTR];
    int checks = 0, errors = 0;
    bit lockstep = 1'b0;
    logic [ND-1:0] busy = '0;
    int cnt [ND];
    logic [ND-1:0] touch_rd, touch_wr;
    int rd_rsp_seen;
    bit order_bad, addr_bad;
    logic [AW-1:0] op_stripe;

    function automatic int exp_pd(input int lba);
        return 4 - ((lba / 4) % 5);
    endfunction

    function automatic int exp_dd(input int lba);
        int idx;
        idx = lba % 4;
        return (idx >= exp_pd(lba)) ? idx + 1 : idx;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // disk models, driven away from the active edge
    always @(negedge clk) begin
        for (int i = 0; i < ND; i++) begin
            dsk_rsp_valid[i] = 1'b0;
            dsk_req_ready[i] = 1'b0;
            if (busy[i]) begin
                if (cnt[i] == 0) begin
                    dsk_rsp_valid[i] = 1'b1;
                    busy[i] = 1'b0;
                    if (!dsk_req_write[i] || touch_rd[i]) rd_rsp_seen++;
                end else cnt[i]--;
            end else if (dsk_req_valid[i] && (lockstep || ($urandom % 2 == 0))) begin
                dsk_req_ready[i] = 1'b1;
                busy[i] = 1'b1;
                cnt[i] = lockstep ? 0 : int'($urandom % 4);
                if (dsk_req_addr[i] != op_stripe || dsk_req_addr[i] >= AW'(NSTR)) addr_bad = 1'b1;
                if (dsk_req_write[i]) begin
                    if (rd_rsp_seen < $countones(touch_rd)) order_bad = 1'b1;
                    touch_wr[i] = 1'b1;
                    if (dsk_req_addr[i] < AW'(NSTR)) dmem[i][dsk_req_addr[i]] = dsk_req_wdata[i];
                end else begin
                    touch_rd[i] = 1'b1;
                    if (dsk_req_addr[i] < AW'(NSTR)) dsk_rsp_rdata[i] = dmem[i][dsk_req_addr[i]];
                end
            end
        end
    end

    task automatic do_op(input bit wr, input int lba, input logic [DW-1:0] data);
        int waited;
        logic [ND-1:0] exp_mask;
        logic [DW-1:0] px;
        bit seen;
        int pd, dd, s;
        pd = exp_pd(lba); dd = exp_dd(lba); s = lba / 4;
        @(negedge clk);
        touch_rd = '0; touch_wr = '0; rd_rsp_seen = 0;
        order_bad = 1'b0; addr_bad = 1'b0; op_stripe = AW'(s);
        req_valid = 1'b1; req_write = wr; req_lba = LW'(lba); req_wdata = data;
        @(negedge clk);
        req_valid = 1'b0;
        waited = 0; seen = 1'b0;
        while (!seen && waited < 300) begin
            if (rsp_done) seen = 1'b1;
            else begin @(negedge clk); waited++; end
        end
        check(seen, "R7", "done pulse arrives (R9 for lockstep)", 32'(waited), 32'(0));
        if (!seen) return;
        if (!wr) check(rsp_rdata == ref_blk[lba], "R8", "read data", rsp_rdata, ref_blk[lba]);
        @(negedge clk);
        check(!rsp_done, "R7", "done lasts one cycle", 32'(rsp_done), 32'(0));
        check(!addr_bad, "R6", "disk address is stripe", 32'(addr_bad), 32'(0));
        if (wr) begin
            ref_blk[lba] = data;
            exp_mask = ND'(1 << pd) | ND'(1 << dd);
            check(touch_rd == exp_mask && touch_wr == exp_mask, "R3", "disks touched",
                  32'({touch_rd, touch_wr}), 32'({exp_mask, exp_mask}));
            check(!order_bad, "R4", "write issued after both reads", 32'(order_bad), 32'(0));
            check(dmem[dd][s] == data, "R2", "data at rotated disk", dmem[dd][s], data);
            px = ref_blk[4*s] ^ ref_blk[4*s+1] ^ ref_blk[4*s+2] ^ ref_blk[4*s+3];
            check(dmem[pd][s] == px, "R1", "parity at rotated disk", dmem[pd][s], px);
            for (int k = 0; k < NSTR; k++) begin
                px = '0;
                for (int j = 0; j < ND; j++) px ^= dmem[j][k];
                check(px == '0, "R5", $sformatf("stripe %0d XOR zero", k), px, '0);
            end
        end else begin
            check(touch_rd == ND'(1 << dd) && touch_wr == '0, "R8", "read touches one disk",
                  32'({touch_rd, touch_wr}), 32'({ND'(1 << dd), ND'(0)}));
        end
    endtask

    initial begin
        void'($urandom(1234));
        for (int i = 0; i < ND; i++) begin
            cnt[i] = 0;
            for (int k = 0; k < NSTR; k++) dmem[i][k] = '0;
        end
        for (int k = 0; k < 4*NSTR; k++) ref_blk[k] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready && !rsp_done && dsk_req_valid == '0, "R7", "reset state",
              32'({req_ready, rsp_done, dsk_req_valid}), 32'({1'b1, 1'b0, 5'b0}));
        // directed: rotation over stripes 0..5, disjoint small writes
        do_op(1'b1, 0, 32'hA5A5_0001);
        do_op(1'b1, 5, 32'h5A5A_0005);
        do_op(1'b1, 7, 32'h0000_0777);
        for (int s = 0; s < 6; s++) do_op(1'b1, 4*s + (s % 4), 32'h1000_0000 + 32'(s));
        do_op(1'b0, 0, '0);
        do_op(1'b0, 7, '0);
        // lockstep: both reads and both acks in the same cycle (R9)
        lockstep = 1'b1;
        for (int n = 0; n < 20; n++) do_op(1'b1, n, $urandom);
        for (int n = 0; n < 8; n++) do_op(1'b0, n * 3, '0);
        lockstep = 1'b0;
        // random mix
        for (int n = 0; n < 300; n++)
            do_op(($urandom % 3) != 0, int'($urandom % (4*NSTR)), $urandom);
        for (int k = 0; k < 4*NSTR; k++) do_op(1'b0, k, '0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        $display("FAIL R7 watchdog expired: actual %0d expected 0", 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule